// File: doc/BRIEF.md
# Programmable Square-Wave Divider

This block makes a square wave with an even duty cycle from a reference tick. The tick arrives as a one-cycle strobe at 65536 Hz, twice the 32768 Hz oscillator rate, on the fast system clock. A 4-bit rate code selects the output frequency. The code 0 turns the output off and holds it low. The code 1 gives the full 32768 Hz. A code n from 2 to 15 gives 32768 >> n Hz, so 8192 Hz for code 2 and 1 Hz for code 15. The output runs only while an enable bit is set.

A byte-wide register port with nibble write masks loads the rate code and the enable bit. The rate code sits in the upper nibble of its register. The lower nibble of that register belongs to other logic and is left alone when only the rate is written. By default the rate register has its own address. When `ALT_LOC` is set, the rate nibble shares the register that holds the weekday instead. A combinational read port returns both registers.

Top module: `sqw_divider`

## Requirements
- R1: After reset `sqOut` is low, and both the rate register and the enable register read 0x00.
- R2: While enable bit 6 of register 0x0A is clear, or while the rate code is 0, `sqOut` is low one clock later and stays low.
- R3: While the output runs, each high phase and each low phase lasts I reference ticks. I = 1 for code 1 and I = 2^n for code n ≥ 2, which gives code 1 → 32768 Hz and code n → 32768 >> n Hz for a 65536 Hz tick.
- R4: With `refTick` held high, the first rise of `sqOut` after the write that starts the output (setting the enable, or making the code nonzero) comes I + 1 clocks after that write's clock edge.
- R5: A write that changes the rate code while the output runs restarts the phase timer, so no edge occurs in the next clock. The next edge comes I_new + 1 clocks after the write edge. Rewriting the same code does not disturb the running wave.
- R6: `wrMask[1]` enables a write of data bits 7:4 and `wrMask[0]` enables a write of bits 3:0. A rate update with mask 2'b10 keeps bits 3:0 of the register.
- R7: The phase timer advances only on cycles where `refTick` is high. With `refTick` low, `sqOut` holds its value.
- R8: The rate register is at address 0x13, or at 0x04 (the weekday register) when `ALT_LOC` = 1. The enable bit is bit 6 at address 0x0A. Writes to any other address change no state, and reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refTick | input | 1 | One-cycle strobe at twice the reference oscillator rate |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrMask | input | 2 | Nibble write enables: bit 1 for data 7:4, bit 0 for data 3:0 |
| wrData | input | 8 | Register write data |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | 8 | Register read data, combinational |
| sqOut | output | 1 | Square-wave output |

## Verification
The assertions take for granted that reset is applied before use and that `refTick` is a clean level, sampled once per clock. They assume no other process changes the registers, so a change of the rate nibble comes only from the write port. The stimulus changes every input on the falling clock edge. It holds `refTick` either high or toggling each cycle, and it issues single-cycle writes with explicit nibble masks, so that each expected edge count follows directly from the rate code.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int RATE_W = 4;
  localparam int DATA_W = 8;
  localparam int CNT_W  = (1 << RATE_W) - 1;

  typedef struct packed {
    logic              hold;      // output forced low, timer parked
    logic              reload;    // restart the phase timer
    logic              step;      // reference tick this cycle
    logic [RATE_W-1:0] shiftExp;  // log2 of the half-period in ticks
  } sqw_ctrl_t;
endpackage

// File: rtl/sqw_ctrl.sv
module sqw_ctrl
  import sqw_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter bit ALT_LOC = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrMask,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] rateByte,
  output logic [DATA_W-1:0] ctlByte,
  output sqw_ctrl_t         ctrl
);
  localparam int NIB = DATA_W / 4;
  localparam logic [ADDR_W-1:0] RATE_ADDR = ALT_LOC ? ADDR_W'(4) : ADDR_W'(19);
  localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(10);
  localparam int EN_BIT = 6;

  logic rateSel, ctlSel;
  assign rateSel = wrEn && (wrAddr == RATE_ADDR);
  assign ctlSel  = wrEn && (wrAddr == EN_ADDR);

  for (genvar g = 0; g < NIB; g++) begin : g_nib
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rateByte[g*4 +: 4] <= '0;
        ctlByte[g*4 +: 4]  <= '0;
      end else begin
        if (rateSel && wrMask[g]) rateByte[g*4 +: 4] <= wrData[g*4 +: 4];
        if (ctlSel && wrMask[g])  ctlByte[g*4 +: 4]  <= wrData[g*4 +: 4];
      end
    end
  end

  logic [RATE_W-1:0] code, lastCode;
  logic active, wasActive;
  assign code   = rateByte[DATA_W-1 -: RATE_W];
  assign active = ctlByte[EN_BIT] && (code != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCode  <= '0;
      wasActive <= 1'b0;
    end else begin
      lastCode  <= code;
      wasActive <= active;
    end
  end

  always_comb begin
    ctrl.hold     = !active;
    ctrl.reload   = active && (!wasActive || (code != lastCode));
    ctrl.step     = refTick;
    ctrl.shiftExp = (code == RATE_W'(1)) ? '0 : code;
  end

  always_comb begin
    if (rdAddr == RATE_ADDR)    rdData = rateByte;
    else if (rdAddr == EN_ADDR) rdData = ctlByte;
    else                        rdData = '0;
  end
endmodule

// File: rtl/sqw_datapath.sv
module sqw_datapath
  import sqw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  sqw_ctrl_t ctrl,
  output logic      sqOut
);
  logic [CNT_W-1:0] phaseCnt, reloadVal;

  assign reloadVal = ~({CNT_W{1'b1}} << ctrl.shiftExp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      sqOut    <= 1'b0;
    end else if (ctrl.hold) begin
      phaseCnt <= reloadVal;
      sqOut    <= 1'b0;
    end else if (ctrl.reload) begin
      phaseCnt <= reloadVal;
    end else if (ctrl.step) begin
      if (phaseCnt == '0) begin
        phaseCnt <= reloadVal;
        sqOut    <= ~sqOut;
      end else begin
        phaseCnt <= phaseCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sqw_divider.sv
module sqw_divider
  import sqw_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter bit ALT_LOC = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrMask,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              sqOut
);
  sqw_ctrl_t ctrl;
  logic [DATA_W-1:0] rateByte, ctlByte;

  sqw_ctrl #(.ADDR_W(ADDR_W), .ALT_LOC(ALT_LOC)) u_ctrl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrMask(wrMask), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .rateByte(rateByte), .ctlByte(ctlByte), .ctrl(ctrl)
  );

  sqw_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sqOut(sqOut)
  );
endmodule

// File: rtl/sqw_divider_chk.sv
module sqw_divider_chk #(
  parameter int ADDR_W  = 5,
  parameter bit ALT_LOC = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              refTick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              sqOut,
  input logic [7:0]        rateByte,
  input logic [7:0]        ctlByte
);
  localparam logic [ADDR_W-1:0] RATE_A = ALT_LOC ? ADDR_W'(4) : ADDR_W'(19);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(10);

  logic       running;
  logic [3:0] prevCode;
  assign running = ctlByte[6] && (rateByte[7:4] != 4'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevCode <= 4'd0;
    else       prevCode <= rateByte[7:4];
  end

  assert_low_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> !sqOut);

  assert_hold_on_rate_change_R5: assert property (@(posedge clk) disable iff (!rstN)
    (running && (rateByte[7:4] != prevCode)) |=> $stable(sqOut));

  assert_still_without_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    (running && !refTick) |=> $stable(sqOut));

  assert_foreign_write_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr != RATE_A) && (wrAddr != EN_A)) |=>
      ($stable(rateByte) && $stable(ctlByte)));
endmodule

bind sqw_divider sqw_divider_chk #(.ADDR_W(ADDR_W), .ALT_LOC(ALT_LOC)) u_chk (
  .clk(clk), .rstN(rstN), .refTick(refTick), .wrEn(wrEn), .wrAddr(wrAddr),
  .sqOut(sqOut), .rateByte(rateByte), .ctlByte(ctlByte)
);

// File: tb/sqw_divider_tb.sv
module sqw_divider_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b1;
  logic       wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [1:0] wrMask = '0;
  logic [7:0] wrData = '0;
  logic [4:0] rdAddr = '0;
  logic [7:0] rdData, rdDataAlt;
  logic       sqOut, sqOutAlt;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int lastEdgeCyc = 0;
  bit edgeValid = 0;
  bit prevOut = 0;
  bit tickAlt = 0;
  int expQ[$];
  string curTag = "";

  always #2 clk = ~clk;  // 250 MHz

  sqw_divider #(.ADDR_W(5), .ALT_LOC(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrMask(wrMask), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .sqOut(sqOut)
  );

  sqw_divider #(.ADDR_W(5), .ALT_LOC(1'b1)) u_dutAlt (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrMask(wrMask), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdDataAlt), .sqOut(sqOutAlt)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: timestamps output edges and pops expected half-periods
  always @(negedge clk) begin
    cyc++;
    if (tickAlt) refTick = ~refTick;
    if (sqOut != prevOut) begin
      if (edgeValid && expQ.size() > 0) check(curTag, cyc - lastEdgeCyc, expQ.pop_front());
      lastEdgeCyc = cyc;
      edgeValid = 1;
    end
    prevOut = sqOut;
  end

  task automatic wr(input logic [4:0] a, input logic [1:0] m, input logic [7:0] d, input bit flush);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrMask = m; wrData = d;
    @(negedge clk);
    wrEn = 0;
    #1;
    if (flush) edgeValid = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v, output logic [7:0] va);
    rdAddr = a;
    #1;
    v = rdData;
    va = rdDataAlt;
  endtask

  task automatic firstEdge(input string tag, input int exp);
    int n = 0;
    bit start = sqOut;
    while (sqOut == start && n < 70000) begin
      @(negedge clk);
      n++;
    end
    check(tag, n, exp);
  endtask

  task automatic expectHalf(input string tag, input int h, input int k);
    int guard = 0;
    curTag = tag;
    for (int i = 0; i < k; i++) expQ.push_back(h);
    while (expQ.size() > 0 && guard < 80000) begin
      @(negedge clk);
      guard++;
    end
    check({tag, " queue drained"}, expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic stayLow(input string tag, input int n);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sqOut) highs++;
    end
    check(tag, highs, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0] v, va;
    int toggles;
    bit ref0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 sqOut after reset", sqOut, 0);
    rd(5'h13, v, va); check("R1 rate reg reset", v, 8'h00);
    rd(5'h0A, v, va); check("R1 enable reg reset", v, 8'h00);

    // R2 code 0 with enable set keeps output low
    wr(5'h13, 2'b11, 8'h05, 1);
    wr(5'h0A, 2'b11, 8'h40, 1);
    stayLow("R2 code 0 low", 50);

    // R6 nibble-masked rate update keeps low nibble; R4 first rise; R3 half period
    wr(5'h13, 2'b10, 8'h3F, 1);
    rd(5'h13, v, va); check("R6 low nibble preserved", v, 8'h35);
    firstEdge("R4 first rise code 3", 9);
    expectHalf("R3 code 3 half period", 8, 6);

    // R5 rate change restarts timer; R3 code 1 exception
    wr(5'h13, 2'b10, 8'h10, 1);
    firstEdge("R5 next edge after change", 2);
    expectHalf("R3 code 1 half period", 1, 6);

    // R7 tick gating
    @(negedge clk); tickAlt = 1;
    repeat (4) @(negedge clk);
    #1 edgeValid = 0;
    expectHalf("R7 alternate tick half period", 2, 6);
    @(negedge clk); tickAlt = 0; refTick = 0;
    @(negedge clk);
    ref0 = sqOut;
    toggles = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sqOut != ref0) toggles++;
    end
    check("R7 no tick holds output", toggles, 0);
    refTick = 1;
    repeat (3) @(negedge clk);
    #1 edgeValid = 0;
    repeat (3) @(negedge clk);

    // R5 same-code rewrite does not disturb the wave
    curTag = "R5 same code rewrite";
    for (int i = 0; i < 10; i++) expQ.push_back(1);
    wr(5'h13, 2'b11, 8'h1A, 0);
    expectHalf("R5 same code rewrite", 1, 0);
    rd(5'h13, v, va); check("R6 full byte write", v, 8'h1A);

    // R2 disable forces low
    wr(5'h0A, 2'b11, 8'h00, 1);
    stayLow("R2 disabled low", 30);

    // R8 foreign address ignored, alternate location
    wr(5'h04, 2'b11, 8'hFF, 1);
    rd(5'h13, v, va); check("R8 rate reg untouched", v, 8'h1A);
    rd(5'h04, v, va); check("R8 unmapped read zero", v, 8'h00);
    check("R8 alt rate at weekday reg", va, 8'hFF);
    rd(5'h13, v, va); check("R8 alt ignores 0x13", va, 8'h00);
    check("R2 alt disabled low", sqOutAlt, 0);

    // R3/R4 boundary code 15
    wr(5'h13, 2'b10, 8'hF0, 1);
    rd(5'h13, v, va); check("R6 code 15 keeps low nibble", v, 8'hFA);
    wr(5'h0A, 2'b01, 8'h0F, 1);
    rd(5'h0A, v, va); check("R6 enable reg low nibble only", v, 8'h0F);
    stayLow("R2 enable bit clear low", 20);
    wr(5'h0A, 2'b10, 8'h40, 1);
    firstEdge("R4 first rise code 15", 32769);
    expectHalf("R3 code 15 half period", 32768, 1);

    summary();
  end
endmodule